// File: doc/BRIEF.md
# Bit-Plane Pixel Serializer with Indexed Colour Table

This block turns planar video memory into colour pixels. Once every eight pixel ticks it takes one byte from each of up to eight bit-planes. It then shifts those bytes out in parallel, so each pixel tick produces an index of up to eight bits with one bit per plane. That index selects a word in a 256-entry colour table, and the word is split into 5-bit red, green and blue channels. The plane fetch logic upstream advances its address whenever the block raises its `take` strobe.

The colour table sits in two byte-wide RAM lanes. The processor writes it one byte at a time, and the display side reads a whole 16-bit word in a single access. A three-bit fine delay shifts the pixel stream right by 0 to 7 ticks, which gives pixel-exact horizontal placement even though the fetch grain is a whole byte. A blank input forces the output to black during border and retrace.

Top module: `plane_palette_out`

## Requirements
- R1: A write with `cpu_addr[0]`=0 stores `cpu_wdata` into bits 7:0 of entry `cpu_addr[8:1]`. A write with `cpu_addr[0]`=1 stores it into bits 15:8 of that entry. The other byte of the entry is left unchanged.
- R2: A displayed entry word W drives `red`=W[14:10], `green`=W[9:5] and `blue`=W[4:0]. Bit 15 of the word has no effect on any output.
- R3: Bit n of the pixel index is taken from plane n, which is `plane_bytes[8n+7:8n]`. A plane whose `plane_en[n]` is 0 when its byte is loaded contributes 0 to that bit.
- R4: Each loaded byte is shown most significant bit first, over eight consecutive pixel ticks. The next bytes are loaded on the eighth tick. `take` is high, together with `pix_en`, exactly on each tick where bytes are loaded.
- R5: A tick with `line_start` high loads the bytes at once and restarts the eight-tick phase, whatever the phase was before.
- R6: While `pix_en` is low, no state advances and `red`, `green` and `blue` hold their values.
- R7: With `fine_dly`=d, the pixel whose byte was loaded at tick L with bit position 7-j appears on the outputs just after tick L+1+j+d.
- R8: A high `blank` at a pixel tick makes all three outputs zero just after that tick. The blank path is not moved by `fine_dly`.
- R9: If a table write and a display read of the same entry fall in the same cycle, the display shows the entry's old word. The new word is shown from the next read onward.
- R10: After reset the outputs are zero, and the first pixel tick loads bytes (`take` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel tick enable, one per displayed pixel |
| line_start | input | 1 | Restart the byte phase and load immediately |
| blank | input | 1 | Border/blanking, forces black |
| plane_en | input | 8 | Per-plane enable |
| plane_bytes | input | 64 | Byte for plane n on bits 8n+7:8n |
| fine_dly | input | 3 | Pixel delay 0 to 7 |
| cpu_we | input | 1 | Table byte write strobe |
| cpu_addr | input | 9 | Table byte address |
| cpu_wdata | input | 8 | Table write byte |
| take | output | 1 | Plane bytes consumed this tick |
| red | output | 5 | Red channel |
| green | output | 5 | Green channel |
| blue | output | 5 | Blue channel |

## Verification
A processor write to a table entry can land in the same cycle that the display is reading that entry. The bench sets up this collision by holding every plane at all ones, so that entry 255 is on screen at every tick. It then writes the low byte of entry 255 during a pixel tick. The check passes if the old word is shown for that tick and the merged word (new low byte, old high byte) for the next one.

// File: rtl/plane_pal_pkg.sv
// Shared types for the plane serializer and colour table.
// Assumes a 16-bit table word with a 5:5:5 colour layout below an unused top bit.
package plane_pal_pkg;
    localparam int CH_W   = 5;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Split a table word into channels; the top bit is dropped.
    function automatic rgb_t word_to_rgb(input logic [WORD_W-1:0] w);
        return rgb_t'(w[3*CH_W-1:0]);
    endfunction
endpackage

// File: rtl/plane_shifter.sv
// Loads one byte per plane on a load tick and shifts all planes MSB first.
// The index bit n is the current top bit of plane n's shift register.
// Assumes plane_bytes is valid in any cycle where take is high.
module plane_shifter #(
    parameter int NPLANES = 8,
    parameter int BYTE_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_en,
    input  logic                      line_start,
    input  logic [NPLANES-1:0]        plane_en,
    input  logic [NPLANES*BYTE_W-1:0] plane_bytes,
    output logic                      take,
    output logic [NPLANES-1:0]        pix_idx
);
    localparam int PH_W = $clog2(BYTE_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);

    logic [PH_W-1:0] phase;

    assign take = pix_en & (line_start | (phase == PH_LAST));

    // Phase counter: restarts on every load, otherwise counts pixel ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= PH_LAST;
        else if (take)   phase <= '0;
        else if (pix_en) phase <= phase + 1'b1;
    end

    for (genvar n = 0; n < NPLANES; n++) begin : g_plane
        logic [BYTE_W-1:0] sr;
        // Per-plane shift register: load masked byte or shift left.
        always_ff @(posedge clk) begin
            if (!rst_n)      sr <= '0;
            else if (take)   sr <= plane_en[n] ? plane_bytes[n*BYTE_W +: BYTE_W] : '0;
            else if (pix_en) sr <= {sr[BYTE_W-2:0], 1'b0};
        end
        assign pix_idx[n] = sr[BYTE_W-1];
    end

    // Independent count of ticks since the last load, for the period check.
    logic [PH_W-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      gap_cnt <= PH_LAST;
        else if (take)   gap_cnt <= '0;
        else if (pix_en && gap_cnt != PH_LAST) gap_cnt <= gap_cnt + 1'b1;
    end

    AST_LOAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !line_start) |-> (gap_cnt == PH_LAST)); // R4
    AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((pix_idx & ~$past(plane_en)) == '0)); // R3
endmodule

// File: rtl/pixel_delay.sv
// Delays the pixel index stream by 0 to 2**DLY_W-1 pixel ticks.
// A delay of zero passes the input straight through without a register.
module pixel_delay #(
    parameter int W     = 8,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [DLY_W-1:0] dly,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    localparam int DEPTH = (1 << DLY_W) - 1;

    logic [W-1:0] taps [DEPTH];

    // Tap line: advances one stage per pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else if (pix_en) begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
    end

    // Tap select: zero bypasses the line.
    always_comb begin
        if (dly == '0) dout = din;
        else           dout = taps[dly - 1'b1];
    end
endmodule

// File: rtl/clut_dual_ram.sv
// Colour table held in two byte-wide lanes: byte writes, full-word reads.
// A read and a write in the same cycle return the old contents.
// Assumes the table contents are loaded by software before display.
module clut_dual_ram #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W:0]   waddr,
    input  logic [7:0]       wdata,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] ridx,
    output logic [15:0]      rword
);
    localparam int ENTRIES = 1 << IDX_W;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [7:0] mem [ENTRIES];
        // Lane write: byte address parity selects the lane.
        always_ff @(posedge clk) begin
            if (we && (waddr[0] == 1'(l))) mem[waddr[IDX_W:1]] <= wdata;
        end
        // Lane read: registered, sees the pre-write contents.
        always_ff @(posedge clk) begin
            if (!rst_n)     rword[l*8 +: 8] <= '0;
            else if (rd_en) rword[l*8 +: 8] <= mem[ridx];
        end
    end
endmodule

// File: rtl/plane_palette_out.sv
// Planar pixel serializer followed by an indexed colour lookup.
// Pipeline per pixel tick: shift -> fine delay -> table read -> blank gate.
// Assumes pix_en marks pixel ticks and plane bytes are valid when take is high.
module plane_palette_out #(
    parameter int NPLANES = 8,
    parameter int BYTE_W  = 8,
    parameter int DLY_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_en,
    input  logic                      line_start,
    input  logic                      blank,
    input  logic [NPLANES-1:0]        plane_en,
    input  logic [NPLANES*BYTE_W-1:0] plane_bytes,
    input  logic [DLY_W-1:0]          fine_dly,
    input  logic                      cpu_we,
    input  logic [NPLANES:0]          cpu_addr,
    input  logic [7:0]                cpu_wdata,
    output logic                      take,
    output logic [4:0]                red,
    output logic [4:0]                green,
    output logic [4:0]                blue
);
    import plane_pal_pkg::*;

    logic [NPLANES-1:0] raw_idx;
    logic [NPLANES-1:0] dly_idx;
    logic [15:0]        tbl_word;
    logic               blank_q;
    rgb_t               col;

    plane_shifter #(.NPLANES(NPLANES), .BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .plane_en(plane_en), .plane_bytes(plane_bytes),
        .take(take), .pix_idx(raw_idx)
    );

    pixel_delay #(.W(NPLANES), .DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .dly(fine_dly),
        .din(raw_idx), .dout(dly_idx)
    );

    clut_dual_ram #(.IDX_W(NPLANES)) u_clut (
        .clk(clk), .rst_n(rst_n), .we(cpu_we), .waddr(cpu_addr),
        .wdata(cpu_wdata), .rd_en(pix_en), .ridx(dly_idx), .rword(tbl_word)
    );

    // Blank flag aligned with the table read stage.
    always_ff @(posedge clk) begin
        if (!rst_n)      blank_q <= 1'b1;
        else if (pix_en) blank_q <= blank;
    end

    assign col   = word_to_rgb(tbl_word);
    assign red   = blank_q ? '0 : col.r;
    assign green = blank_q ? '0 : col.g;
    assign blue  = blank_q ? '0 : col.b;

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && blank) |=> ({red, green, blue} == '0)); // R8
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable({red, green, blue})); // R6
endmodule

// File: tb/plane_palette_out_tb.sv
module plane_palette_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0, line_start = 1'b0, blank = 1'b0;
    logic [7:0]  plane_en = '0;
    logic [63:0] plane_bytes = '0;
    logic [2:0]  fine_dly = '0;
    logic        cpu_we = 1'b0;
    logic [8:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        take;
    logic [4:0]  red, green, blue;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [256];
    localparam int NPIX = 64;

    always #2 clk = ~clk;

    plane_palette_out u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .blank(blank), .plane_en(plane_en), .plane_bytes(plane_bytes),
        .fine_dly(fine_dly), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .take(take), .red(red), .green(green), .blue(blue)
    );

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int g, input int n, input int s);
        return 8'(((g * 37) + (n * 91) + (s * 13)) ^ 165);
    endfunction

    function automatic logic [15:0] tword(input int i);
        return 16'((i * 40503) ^ 15510);
    endfunction

    function automatic logic [7:0] pidx(input int p, input logic [7:0] m, input int s);
        logic [7:0] r = '0;
        for (int n = 0; n < 8; n++)
            if (m[n]) r[n] = pbyte(p / 8, n, s)[7 - (p % 8)];
        return r;
    endfunction

    // R1: even byte address -> low half, odd -> high half of entry addr[8:1].
    task automatic cpu_write(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a[0]) model[a[8:1]][15:8] = d;
        else      model[a[8:1]][7:0]  = d;
    endtask

    task automatic run_line(input string req, input int d, input logic [7:0] m,
                            input int s, input bit stall, input bit blk);
        int t = -1;
        logic [14:0] prev;
        bit bl [NPIX + 16];
        fine_dly = 3'(d); plane_en = m;
        @(negedge clk);
        prev = {red, green, blue};
        for (int c = 0; c < 400 && t < NPIX + d; c++) begin
            bit pe = stall ? (c % 2 == 0) : 1'b1;
            int nt = pe ? t + 1 : t;
            pix_en = pe;
            line_start = pe && (nt == 0);
            plane_bytes = '0;
            for (int n = 0; n < 8; n++) plane_bytes[n*8 +: 8] = pbyte(nt / 8, n, s);
            blank = blk && pe && (nt % 11 == 4);
            if (pe) bl[nt] = blank;
            #1;
            if (pe) check(nt == 0 ? "R5" : "R4", 15'(take), 15'(nt % 8 == 0));
            @(posedge clk); @(negedge clk);
            if (pe) begin
                int p;
                t = nt; p = t - 1 - d;
                if (p >= 0 && p < NPIX)
                    check(bl[t] ? "R8" : req, {red, green, blue},
                          bl[t] ? 15'h0 : model[pidx(p, m, s)][14:0]);
            end else begin
                check("R6", {red, green, blue}, prev);
            end
            prev = {red, green, blue};
        end
        pix_en = 1'b0; line_start = 1'b0; blank = 1'b0;
    endtask

    // R9: same-cycle write and display read of entry 255.
    task automatic collide;
        logic [15:0] oldw;
        fine_dly = '0; plane_en = 8'hFF; plane_bytes = '1;
        @(negedge clk);
        pix_en = 1'b1; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (3) @(negedge clk);
        oldw = model[255];
        cpu_we = 1'b1; cpu_addr = 9'h1FE; cpu_wdata = 8'h00;
        @(negedge clk);
        cpu_we = 1'b0;
        check("R9", {red, green, blue}, oldw[14:0]);
        model[255][7:0] = 8'h00;
        @(negedge clk);
        check("R9", {red, green, blue}, model[255][14:0]);
        pix_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {red, green, blue}, 15'h0);
        pix_en = 1'b1; #1;
        check("R10", 15'(take), 15'h1);
        pix_en = 1'b0;
        for (int i = 0; i < 256; i++) begin
            cpu_write(9'(2 * i), tword(i)[7:0]);
            cpu_write(9'(2 * i + 1), tword(i)[15:8]);
        end
        run_line("R1", 0, 8'hFF, 1, 1'b0, 1'b0);
        run_line("R2", 0, 8'hFF, 2, 1'b0, 1'b0);
        run_line("R3", 0, 8'h01, 3, 1'b0, 1'b0);
        run_line("R3", 2, 8'hA5, 4, 1'b0, 1'b0);
        run_line("R3", 0, 8'h00, 5, 1'b0, 1'b0);
        for (int d = 1; d < 8; d++) run_line("R7", d, 8'hFF, 6 + d, 1'b0, 1'b0);
        run_line("R6", 3, 8'h3C, 20, 1'b1, 1'b0);
        run_line("R8", 5, 8'hFF, 21, 1'b0, 1'b1);
        cpu_write(9'h0AB, 8'hC3);
        run_line("R1", 1, 8'hFF, 22, 1'b0, 1'b0);
        collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule